// File: doc/BRIEF.md
# Clock-Synchronous DRAM Access Sequencer

This block turns a processor access request into the row strobe, column strobe and address multiplexer sequence of an asynchronous DRAM array, with every edge tied to the system clock. A request is presented as an address strobe qualified by a chip select, together with a row address and a column address. The sequencer drives the row onto the memory address bus, holds it for a programmed number of cycles, switches to the column and asserts the column strobe. It then counts a programmed number of wait states and returns a one-cycle acknowledge.

Two operating styles are selected by configuration. In normal style the row strobe is released after each access, once a programmed minimum low time has passed, and a programmed precharge interval follows. In page style the row stays open after the access. A later request to the same row is served with a column cycle only. A request to a different row closes the row, precharges and reopens. The same-row decision comes from an internal comparator against the open row, or from an external hit input. A grant input floats all memory-side outputs so that another controller can drive the array.

The request interface follows a valid/ready rule. `acc_ready` is high only while the sequencer is idle or holding an open page. A strobe with select counts as taken only on a rising edge where `acc_ready` is high. A strobe presented while `acc_ready` is low is dropped, not stored, and the requester must present it again. Configuration inputs must only change while the sequencer is idle.

Top module: `dram_seq`

## Requirements
- R1: After reset `ras_n` and `cas_n` are high, `ack` and `mux_col` are low and `acc_ready` is high.
- R2: A request is taken only on a rising edge where `acc_strobe`, `acc_sel` and `acc_ready` are all high. A strobe without select, or a strobe while `acc_ready` is low, causes no strobe activity and no acknowledge.
- R3: For a request taken from idle, `ras_n` falls on the same rising edge that takes it, and the row address is on `dram_addr` (`mux_col` low).
- R4: `cas_n` falls and `mux_col` rises `cfg_row_hold` edges after `ras_n` falls. A hold value of 0 acts as 1. While `cas_n` is low, `dram_addr` carries the column address.
- R5: `ack` is high for exactly one cycle. It rises `cfg_open_wait`+1 edges after `cas_n` falls on an opening access, on the same edge where `cas_n` rises.
- R6: In normal style `ras_n` rises on edge max(E0+`cfg_ras_low`, Ea+1), where E0 is the `ras_n` fall edge and Ea the `ack` edge. `acc_ready` returns `cfg_precharge`+1 edges after that.
- R7: In page style `ras_n` stays low after the acknowledge, and `acc_ready` rises on the `ack` edge.
- R8: A page hit in page style drops `cas_n` on the taking edge, with `ras_n` untouched. `ack` follows `cfg_page_wait`+1 edges later.
- R9: A page miss raises `ras_n` on the taking edge. `ras_n` falls again `cfg_precharge`+1 edges later with the new row on `dram_addr`, and the access then runs with opening timing (R4, R5).
- R10: With `cfg_ext_cmp` low a hit means the row input equals the open row. With `cfg_ext_cmp` high a hit means `ext_hit` is high, whatever the row.
- R11: While `grant` is high, `ras_n`, `cas_n` and `dram_addr` are high impedance. Sequencer state is unaffected, so the previous levels return when `grant` falls.
- R12: `acc_ready` falls on the edge that takes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_strobe | input | 1 | Address strobe (request valid) |
| acc_sel | input | 1 | Chip select qualifying the strobe |
| row_addr | input | AW | Row part of the request address |
| col_addr | input | AW | Column part of the request address |
| ext_hit | input | 1 | External same-row indication |
| cfg_page_mode | input | 1 | 1 = page style, 0 = normal style |
| cfg_ext_cmp | input | 1 | 1 = use `ext_hit`, 0 = internal comparator |
| cfg_row_hold | input | CW | Row hold cycles before column switch |
| cfg_ras_low | input | CW | Minimum row strobe low cycles (normal style) |
| cfg_open_wait | input | CW | Wait states of an opening access |
| cfg_page_wait | input | CW | Wait states of a page-hit access |
| cfg_precharge | input | CW | Precharge cycles after row strobe release |
| grant | input | 1 | High floats the memory-side outputs |
| acc_ready | output | 1 | Request can be taken this cycle |
| ack | output | 1 | One-cycle end-of-access pulse |
| mux_col | output | 1 | Address multiplexer selects the column |
| ras_n | output | 1 | Row strobe, active low, tri-state |
| cas_n | output | 1 | Column strobe, active low, tri-state |
| dram_addr | output | AW | Multiplexed memory address, tri-state |

## Verification
In normal style two timers end together. The minimum row-low timer can run out on the same edge that the access itself finishes and would release the row. Three settings of `cfg_ras_low` put the timer's end before, exactly on, and after the edge following the acknowledge. The bench computes the expected release edge as the later of the two in every case, so an off-by-one in either path is seen as a shifted `ras_n` rise. A second collision is a stray strobe arriving while an access is in flight. The scoreboard would see it as an extra, unqueued strobe event.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RHOLD = 3'd1,
    ST_CWAIT = 3'd2,
    ST_CLOSE = 3'd3,
    ST_PRE   = 3'd4,
    ST_PHOLD = 3'd5,
    ST_MISS  = 3'd6
  } seq_state_e;

  function automatic logic row_open(input seq_state_e s);
    return (s == ST_RHOLD) || (s == ST_CWAIT) || (s == ST_CLOSE) || (s == ST_PHOLD);
  endfunction
endpackage

// File: rtl/dram_seq_cnt.sv
module dram_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (!zero)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  p_cnt_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/dram_seq_pagecmp.sv
module dram_seq_pagecmp #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] row_in,
  input  logic          ext_hit,
  input  logic          use_ext,
  output logic          hit,
  output logic [AW-1:0] open_row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_row <= '0;
    else if (capture) open_row <= row_in;
  end

  assign hit = use_ext ? ext_hit : (row_in == open_row);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          hit,
  input  logic          cfg_page_mode,
  input  logic [CW-1:0] cfg_row_hold,
  input  logic [CW-1:0] cfg_ras_low,
  input  logic [CW-1:0] cfg_open_wait,
  input  logic [CW-1:0] cfg_page_wait,
  input  logic [CW-1:0] cfg_precharge,
  input  logic          ph_zero,
  input  logic          ras_zero,
  output logic          ph_load,
  output logic [CW-1:0] ph_val,
  output logic          ras_load,
  output logic [CW-1:0] ras_val,
  output logic          ready,
  output logic          ras_q,
  output logic          cas_q,
  output logic          mux_q,
  output logic          ack_q
);
  seq_state_e st, nxt;
  logic [CW-1:0] hold_m1;

  assign hold_m1 = (cfg_row_hold == '0) ? '0 : cfg_row_hold - 1'b1;
  assign ras_val = (cfg_ras_low == '0) ? '0 : cfg_ras_low - 1'b1;
  assign ready   = (st == ST_IDLE) || (st == ST_PHOLD);

  always_comb begin
    nxt      = st;
    ph_load  = 1'b0;
    ph_val   = '0;
    ras_load = 1'b0;
    unique case (st)
      ST_IDLE: if (take) begin
        nxt = ST_RHOLD; ph_load = 1'b1; ph_val = hold_m1; ras_load = 1'b1;
      end
      ST_PHOLD: if (take) begin
        ph_load = 1'b1;
        if (hit) begin nxt = ST_CWAIT; ph_val = cfg_page_wait; end
        else     begin nxt = ST_MISS;  ph_val = cfg_precharge; end
      end
      ST_MISS: if (ph_zero) begin
        nxt = ST_RHOLD; ph_load = 1'b1; ph_val = hold_m1; ras_load = 1'b1;
      end
      ST_RHOLD: if (ph_zero) begin
        nxt = ST_CWAIT; ph_load = 1'b1; ph_val = cfg_open_wait;
      end
      ST_CWAIT: if (ph_zero) nxt = cfg_page_mode ? ST_PHOLD : ST_CLOSE;
      ST_CLOSE: if (ras_zero) begin
        nxt = ST_PRE; ph_load = 1'b1; ph_val = cfg_precharge;
      end
      ST_PRE: if (ph_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      mux_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st    <= nxt;
      ras_q <= !row_open(nxt);
      cas_q <= (nxt != ST_CWAIT);
      mux_q <= (nxt == ST_CWAIT);
      ack_q <= (st == ST_CWAIT) && ph_zero;
    end
  end

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_ack_cas_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> cas_q);
  p_cas_needs_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_q |-> !ras_q);
  p_cas_on_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_q |-> mux_q);
  p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PHOLD) |-> !ras_q);
  p_ras_low_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_q) && !cfg_page_mode) |-> $past(ras_zero));
  p_busy_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !ph_zero) |=> $stable(cas_q));
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_strobe,
  input  logic          acc_sel,
  input  logic [AW-1:0] row_addr,
  input  logic [AW-1:0] col_addr,
  input  logic          ext_hit,
  input  logic          cfg_page_mode,
  input  logic          cfg_ext_cmp,
  input  logic [CW-1:0] cfg_row_hold,
  input  logic [CW-1:0] cfg_ras_low,
  input  logic [CW-1:0] cfg_open_wait,
  input  logic [CW-1:0] cfg_page_wait,
  input  logic [CW-1:0] cfg_precharge,
  input  logic          grant,
  output logic          acc_ready,
  output logic          ack,
  output logic          mux_col,
  output wire           ras_n,
  output wire           cas_n,
  output wire  [AW-1:0] dram_addr
);
  logic          take, hit;
  logic          ph_load, ph_zero, ras_load, ras_zero;
  logic [CW-1:0] ph_val, ras_val;
  logic          ras_q, cas_q;
  logic [AW-1:0] open_row, col_q;

  assign take = acc_strobe && acc_sel && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    col_q <= '0;
    else if (take) col_q <= col_addr;
  end

  dram_seq_pagecmp #(.AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .capture(take), .row_in(row_addr),
    .ext_hit(ext_hit), .use_ext(cfg_ext_cmp), .hit(hit), .open_row(open_row)
  );

  dram_seq_cnt #(.W(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  dram_seq_cnt #(.W(CW)) u_raslow (
    .clk(clk), .rst_n(rst_n), .load(ras_load), .load_val(ras_val), .zero(ras_zero)
  );

  dram_seq_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(hit),
    .cfg_page_mode(cfg_page_mode), .cfg_row_hold(cfg_row_hold),
    .cfg_ras_low(cfg_ras_low), .cfg_open_wait(cfg_open_wait),
    .cfg_page_wait(cfg_page_wait), .cfg_precharge(cfg_precharge),
    .ph_zero(ph_zero), .ras_zero(ras_zero),
    .ph_load(ph_load), .ph_val(ph_val), .ras_load(ras_load), .ras_val(ras_val),
    .ready(acc_ready), .ras_q(ras_q), .cas_q(cas_q), .mux_q(mux_col), .ack_q(ack)
  );

  assign ras_n     = grant ? 1'bz : ras_q;
  assign cas_n     = grant ? 1'bz : cas_q;
  assign dram_addr = grant ? {AW{1'bz}} : (mux_col ? col_q : open_row);

  p_take_drops_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !acc_ready);
  p_no_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && !take && ras_q) |=> !ack);
endmodule

// File: tb/test_dram_seq.sv
`timescale 1ns/1ps
module test_dram_seq;
  localparam int AW = 10;
  localparam int CW = 4;
  localparam int K_RF = 0, K_RR = 1, K_CF = 2, K_CR = 3, K_AK = 4, K_YF = 5, K_YR = 6;

  typedef struct {
    int          kind;
    int          cyc;
    logic [AW-1:0] addr;
    bit          chk_addr;
    string       req;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic acc_strobe = 0, acc_sel = 0, ext_hit = 0;
  logic [AW-1:0] row_addr = '0, col_addr = '0;
  logic cfg_page_mode = 0, cfg_ext_cmp = 0, grant = 0;
  logic [CW-1:0] cfg_row_hold = 2, cfg_ras_low = 6, cfg_open_wait = 1;
  logic [CW-1:0] cfg_page_wait = 0, cfg_precharge = 2;
  logic acc_ready, ack, mux_col;
  wire  ras_n, cas_n;
  wire  [AW-1:0] dram_addr;

  int total = 0, bad = 0, cyc = 0;
  ev_t q[$];
  bit page_open = 0;
  logic [AW-1:0] open_row_m = '0;
  logic p_ras = 1, p_cas = 1, p_ack = 0, p_rdy = 1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_seq #(.AW(AW), .CW(CW)) i_dram_seq (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_sel(acc_sel),
    .row_addr(row_addr), .col_addr(col_addr), .ext_hit(ext_hit),
    .cfg_page_mode(cfg_page_mode), .cfg_ext_cmp(cfg_ext_cmp),
    .cfg_row_hold(cfg_row_hold), .cfg_ras_low(cfg_ras_low),
    .cfg_open_wait(cfg_open_wait), .cfg_page_wait(cfg_page_wait),
    .cfg_precharge(cfg_precharge), .grant(grant),
    .acc_ready(acc_ready), .ack(ack), .mux_col(mux_col),
    .ras_n(ras_n), .cas_n(cas_n), .dram_addr(dram_addr)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int c, input logic [AW-1:0] a, input bit ca, input string rq);
    ev_t e;
    e.kind = k; e.cyc = c; e.addr = a; e.chk_addr = ca; e.req = rq;
    q.push_back(e);
  endtask

  function automatic int hold_eff();
    return (cfg_row_hold == 0) ? 1 : int'(cfg_row_hold);
  endfunction

  // opening part shared by idle opens and miss reopens; e = ras_n fall edge
  task automatic push_open(input int e, input int e0, input logic [AW-1:0] r,
                           input logic [AW-1:0] c, input bit from_idle);
    int ec, ea, er;
    ec = e + hold_eff();
    ea = ec + 1 + int'(cfg_open_wait);
    if (from_idle) begin
      push(K_RF, e, r, 1, "R3");
      push(K_YF, e0, '0, 0, "R12");
    end else begin
      push(K_RF, e, r, 1, "R9");
    end
    push(K_CF, ec, c, 1, "R4");
    push(K_CR, ea, '0, 0, "R5");
    push(K_AK, ea, '0, 0, "R5");
    if (cfg_page_mode) begin
      push(K_YR, ea, '0, 0, "R7");
      page_open = 1;
      open_row_m = r;
    end else begin
      er = (e + int'(cfg_ras_low) > ea + 1) ? e + int'(cfg_ras_low) : ea + 1;
      push(K_RR, er, '0, 0, "R6");
      push(K_YR, er + int'(cfg_precharge) + 1, '0, 0, "R6");
    end
  endtask

  task automatic access(input logic [AW-1:0] r, input logic [AW-1:0] c, input bit eh);
    int e0, ea, eo;
    bit h;
    do @(negedge clk); while (!acc_ready);
    acc_strobe = 1; acc_sel = 1; row_addr = r; col_addr = c; ext_hit = eh;
    e0 = cyc + 1;
    if (!page_open) begin
      push_open(e0, e0, r, c, 1);
    end else begin
      h = cfg_ext_cmp ? eh : (r == open_row_m);
      if (h) begin
        ea = e0 + 1 + int'(cfg_page_wait);
        push(K_CF, e0, c, 1, "R8");
        push(K_YF, e0, '0, 0, "R12");
        push(K_CR, ea, '0, 0, "R8");
        push(K_AK, ea, '0, 0, "R8");
        push(K_YR, ea, '0, 0, "R7");
      end else begin
        push(K_RR, e0, '0, 0, "R9");
        push(K_YF, e0, '0, 0, "R12");
        eo = e0 + 1 + int'(cfg_precharge);
        push_open(eo, e0, r, c, 0);
      end
    end
    @(negedge clk);
    acc_strobe = 0; acc_sel = 0; ext_hit = 0;
  endtask

  task automatic drain(input string rq);
    repeat (40) @(negedge clk);
    chk(q.size() == 0, rq, $sformatf("%0d pending", q.size()), "0 pending");
  endtask

  task automatic do_reset();
    rst_n = 0;
    page_open = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // monitor: one scoreboard entry per observed edge event
  task automatic see(input int k);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, "R2", $sformatf("kind %0d at %0d", k, cyc), "no event");
    end else begin
      e = q.pop_front();
      chk(e.kind == k && e.cyc == cyc && (!e.chk_addr || dram_addr === e.addr), e.req,
          $sformatf("kind %0d cyc %0d addr %h", k, cyc, dram_addr),
          $sformatf("kind %0d cyc %0d addr %h", e.kind, e.cyc, e.addr));
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_ack = 0; p_rdy = 1;
    end else if (!grant) begin
      if (p_ras && !ras_n) see(K_RF);
      if (!p_ras && ras_n) see(K_RR);
      if (p_cas && !cas_n) see(K_CF);
      if (!p_cas && cas_n) see(K_CR);
      if (!p_ack && ack)   see(K_AK);
      if (p_ack && ack)    chk(0, "R5", "ack high two cycles", "one cycle");
      if (p_rdy && !acc_ready) see(K_YF);
      if (!p_rdy && acc_ready) see(K_YR);
      p_ras = ras_n; p_cas = cas_n; p_ack = ack; p_rdy = acc_ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "timeout", "finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(ras_n === 1'b1 && cas_n === 1'b1 && ack === 1'b0 && acc_ready === 1'b1 && mux_col === 1'b0,
        "R1", $sformatf("%b%b%b%b%b", ras_n, cas_n, ack, acc_ready, mux_col), "11010");

    // R2 strobe without select ignored
    @(negedge clk); acc_strobe = 1; acc_sel = 0;
    @(negedge clk); acc_strobe = 0;
    repeat (3) @(negedge clk);
    chk(acc_ready === 1'b1 && ras_n === 1'b1, "R2", $sformatf("%b%b", acc_ready, ras_n), "11");

    // normal style: ras low time dominates, ack dominates, both coincide
    cfg_page_mode = 0; cfg_row_hold = 2; cfg_open_wait = 1; cfg_precharge = 2;
    cfg_ras_low = 6; access(10'h012, 10'h034, 0);
    // stray strobe while busy (R2)
    @(negedge clk); acc_strobe = 1; acc_sel = 1;
    @(negedge clk); acc_strobe = 0; acc_sel = 0;
    drain("R6");
    cfg_ras_low = 3; access(10'h0A5, 10'h15A, 0); drain("R6");
    cfg_ras_low = 5; access(10'h3FF, 10'h001, 0); drain("R6");
    cfg_row_hold = 0; cfg_open_wait = 0; cfg_precharge = 0; cfg_ras_low = 0;
    access(10'h200, 10'h2AA, 0); drain("R4");

    // page style, internal comparator
    do_reset();
    cfg_page_mode = 1; cfg_ext_cmp = 0; cfg_row_hold = 1; cfg_open_wait = 2;
    cfg_page_wait = 1; cfg_precharge = 1;
    access(10'h111, 10'h010, 0);
    access(10'h111, 10'h011, 0);
    access(10'h111, 10'h012, 0);
    access(10'h222, 10'h020, 0);
    access(10'h222, 10'h021, 0);
    drain("R8");
    // R7 row stays open, R2 strobe without select in page hold
    chk(ras_n === 1'b0 && acc_ready === 1'b1, "R7", $sformatf("%b%b", ras_n, acc_ready), "01");
    @(negedge clk); acc_strobe = 1; acc_sel = 0;
    @(negedge clk); acc_strobe = 0;
    repeat (3) @(negedge clk);
    chk(ras_n === 1'b0 && cas_n === 1'b1 && ack === 1'b0, "R2",
        $sformatf("%b%b%b", ras_n, cas_n, ack), "010");
    // R11 grant floats memory side
    grant = 1;
    @(negedge clk);
    chk(ras_n === 1'bz && cas_n === 1'bz && dram_addr === {AW{1'bz}}, "R11",
        $sformatf("%b %b %h", ras_n, cas_n, dram_addr), "z z zzz");
    grant = 0;
    @(negedge clk);
    chk(ras_n === 1'b0 && cas_n === 1'b1 && dram_addr === 10'h222, "R11",
        $sformatf("%b %b %h", ras_n, cas_n, dram_addr), "0 1 222");

    // page style, external hit source (R10)
    do_reset();
    cfg_ext_cmp = 1; cfg_page_wait = 3; cfg_precharge = 3;
    access(10'h055, 10'h100, 0);
    access(10'h0AA, 10'h101, 1);
    access(10'h055, 10'h102, 0);
    drain("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule